// File: doc/BRIEF.md
# Baud Rate Generator with Live-Count Readback and Timer Mode

This block produces the bit-rate tick for a serial receiver and transmitter. A down-counter of `CNT_W` bits is loaded from a programmed reload value. It counts once per system clock and emits a one-clock tick each time it reaches zero. Software programs the reload value one byte at a time, through separate high and low byte addresses on a small byte-wide register port.

One control bit has two uses. Its effect depends on the receiver-enable input. With the receiver enabled, the bit only chooses what the two reload addresses read back: the programmed reload value (bit clear) or the live count (bit set). With the receiver disabled and the bit set, the generator also becomes a free-running interval timer and raises the receive interrupt on every zero count. The live count is read without any cross-byte latching, so each byte is a snapshot of the moment it is read.

A three-state mode machine holds the current view:
- `MODE_RELOAD_VIEW`: control bit clear.
- `MODE_LIVE_VIEW`: bit set, receiver enabled.
- `MODE_TIMER`: bit set, receiver disabled.

On every clock the machine takes the transition chosen by the control bit and `rx_en`, from whatever state it is in:
- "clear": go to `MODE_RELOAD_VIEW` whenever the bit is 0.
- "live": go to `MODE_LIVE_VIEW` when the bit is 1 and `rx_en` is 1.
- "arm": go to `MODE_TIMER` when the bit is 1 and `rx_en` is 0.

The state register adds one clock of latency between a change of the bit or of `rx_en` and its effect. The state leaves reset in `MODE_RELOAD_VIEW`.

Top module: `baud_gen_ctl`

## Requirements
- R1: After reset, the reload value is 0, the control bit is 0, the count is 0, reads of addresses 0, 1 and 2 return 0, and `rx_irq` is low.
- R2: With reload value N ≥ 1, `baud_tick` is high for exactly one clock every N clocks.
- R3: A reload value of 0 behaves as 1, so `baud_tick` is high on every clock.
- R4: A write to either reload byte (address 0 = bits 15:8, address 1 = bits 7:0) does not change the running count. The new value is first loaded when the count next reaches zero.
- R5: While the mode is `MODE_RELOAD_VIEW`, reading address 0 returns reload bits 15:8 and reading address 1 returns reload bits 7:0.
- R6: While the mode is `MODE_LIVE_VIEW` or `MODE_TIMER`, reading address 0 returns count bits 15:8 and reading address 1 returns count bits 7:0. The count runs N-1 down to 0, and `baud_tick` is high at 0.
- R7: In `MODE_TIMER`, `rx_irq` is high in exactly the clocks in which `baud_tick` is high.
- R8: With `rx_en` high, `rx_irq` stays low whatever the control bit. The bit then only changes readback.
- R9: With the control bit clear, `rx_irq` stays low.
- R10: The two count bytes are not latched against each other. A read of address 1 in the clock after a read of address 0 returns the low byte of the count in that later clock.
- R11: Address 2 holds the control bit at bit 0 (written from `wr_data[0]`, read back with bits 7:1 zero). Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 high reload byte, 1 low reload byte, 2 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (combinational read) |
| rd_data | output | 8 | Read data |
| rx_en | input | 1 | Receiver enable |
| baud_tick | output | 1 | One-clock bit-rate tick at each zero count |
| rx_irq | output | 1 | Receive interrupt from the timer mode |

## Verification
On every clock, the assertions check the following:
- the tick is one clock wide for periods above one;
- the count decrements by one between ticks;
- the interrupt coincides with a tick and appears only after a cycle with the receiver disabled and the control bit set;
- a live low-byte read matches the counter.

Only the bench's scenarios can show the measured tick period across a sweep of reload values, including zero. They also show the deferred effect of a reload written mid-count, reload readback against written values, and the unlatched high/low count reads around a byte boundary.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic [1:0] {
        MODE_RELOAD_VIEW = 2'd0,
        MODE_LIVE_VIEW   = 2'd1,
        MODE_TIMER       = 2'd2
    } baud_mode_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  reload_q,
    output logic              ctl_q
);
    localparam int NUM_BYTES = CNT_W / BYTE_W;

    // Byte lane i sits at address NUM_BYTES-1-i (most significant byte at address 0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctl_q    <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (wr_addr == ADDR_W'(NUM_BYTES - 1 - i))
                    reload_q[i*BYTE_W +: BYTE_W] <= wr_data;
            end
            if (wr_addr == ADDR_W'(NUM_BYTES))
                ctl_q <= wr_data[0];
        end
    end

    // R4
    reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(reload_q));
endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_q,
    output logic             tick
);
    logic [CNT_W-1:0] eff_reload;

    always_comb begin
        eff_reload = (reload == '0) ? CNT_W'(1) : reload;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (count_q == '0)
            count_q <= eff_reload - CNT_W'(1);
        else
            count_q <= count_q - CNT_W'(1);
    end

    assign tick = (count_q == '0);

    // R2
    tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload > CNT_W'(1)) |=> !tick);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (count_q == $past(count_q) - CNT_W'(1)));
endmodule

// File: rtl/baud_mode_fsm.sv
module baud_mode_fsm
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl,
    input  logic       rx_en,
    input  logic       tick,
    output baud_mode_e mode_q,
    output logic       live_view,
    output logic       irq
);
    baud_mode_e mode_d;

    // Transitions: clear / live / arm, taken from any state.
    always_comb begin
        if (!ctl)
            mode_d = MODE_RELOAD_VIEW;
        else if (rx_en)
            mode_d = MODE_LIVE_VIEW;
        else
            mode_d = MODE_TIMER;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_RELOAD_VIEW;
        else
            mode_q <= mode_d;
    end

    always_comb begin
        live_view = 1'b0;
        irq       = 1'b0;
        unique case (mode_q)
            MODE_RELOAD_VIEW: begin
                live_view = 1'b0;
                irq       = 1'b0;
            end
            MODE_LIVE_VIEW: begin
                live_view = 1'b1;
                irq       = 1'b0;
            end
            MODE_TIMER: begin
                live_view = 1'b1;
                irq       = tick;
            end
            default: begin
                live_view = 1'b0;
                irq       = 1'b0;
            end
        endcase
    end

    // R7
    irq_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tick);

    // R8
    irq_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(rx_en));

    // R9
    irq_ctl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctl));
endmodule

// File: rtl/baud_gen_ctl.sv
module baud_gen_ctl
    import baud_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              rx_en,
    output logic              baud_tick,
    output logic              rx_irq
);
    localparam int NUM_BYTES = CNT_W / BYTE_W;

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic             ctl_q;
    logic             live_view;
    logic             tick;
    baud_mode_e       mode_q;
    logic [CNT_W-1:0] view_src;

    baud_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .reload_q (reload_q),
        .ctl_q    (ctl_q)
    );

    baud_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (reload_q),
        .count_q (count_q),
        .tick    (tick)
    );

    baud_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl_q),
        .rx_en     (rx_en),
        .tick      (tick),
        .mode_q    (mode_q),
        .live_view (live_view),
        .irq       (rx_irq)
    );

    assign baud_tick = tick;
    assign view_src  = live_view ? count_q : reload_q;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_addr == ADDR_W'(NUM_BYTES - 1 - i))
                rd_data = view_src[i*BYTE_W +: BYTE_W];
        end
        if (rd_addr == ADDR_W'(NUM_BYTES))
            rd_data = BYTE_W'(ctl_q);
    end

    // R6
    live_low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_RELOAD_VIEW && rd_addr == ADDR_W'(NUM_BYTES - 1))
            |-> rd_data == count_q[BYTE_W-1:0]);

    // R11
    ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(NUM_BYTES)) |-> rd_data[BYTE_W-1:1] == '0);
endmodule

// File: tb/tb_baud_gen_ctl.sv
`timescale 1ns/1ps
module tb_baud_gen_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       rx_en = 1'b0;
    logic       baud_tick;
    logic       rx_irq;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    baud_gen_ctl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rx_en     (rx_en),
        .baud_tick (baud_tick),
        .rx_irq    (rx_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic set_reload(input int n);
        wr(2'd0, 8'((n >> 8) & 255));
        wr(2'd1, 8'(n & 255));
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            if (baud_tick) return;
        end
        check("R2 tick timeout", 0, 1);
    endtask

    task automatic gap(output int n);
        n = 0;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            n++;
            if (baud_tick) return;
        end
    endtask

    initial begin
        #2000000;
        miscompares++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int v, g, eff;
        // R1 / R3: reset state, tick every clock with reload 0
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R3 tick each clock after reset", int'(baud_tick), 1);
            check("R1 irq low after reset", int'(rx_irq), 0);
        end
        rd(2'd0, v); check("R1 read addr0", v, 0);
        rd(2'd1, v); check("R1 read addr1", v, 0);
        rd(2'd2, v); check("R1 read ctl", v, 0);

        // R2 / R3 / R5: sweep of reload values, readback of reload
        for (int n = 0; n < 30; n++) begin
            set_reload(n);
            rd(2'd0, v); check("R5 reload high readback", v, (n >> 8) & 255);
            rd(2'd1, v); check("R5 reload low readback", v, n & 255);
            wait_tick();
            eff = (n == 0) ? 1 : n;
            for (int p = 0; p < 2; p++) begin
                gap(g);
                check(n == 0 ? "R3 period for zero reload" : "R2 tick period", g, eff);
            end
        end
        for (int j = 0; j < 3; j++) begin
            int n;
            n = (j == 0) ? 255 : (j == 1) ? 256 : 1000;
            set_reload(n);
            rd(2'd0, v); check("R5 reload high readback", v, (n >> 8) & 255);
            rd(2'd1, v); check("R5 reload low readback", v, n & 255);
            wait_tick();
            gap(g); check("R2 tick period large", g, n);
        end

        // R4: mid-count reload write takes effect only at the next zero
        set_reload(40);
        wait_tick();
        wait_tick();
        set_reload(7);
        gap(g); check("R4 running period kept after write", g, 36);
        gap(g); check("R4 new period after reload", g, 7);

        // R11: control address and unused address
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check("R11 ctl bit readback set", v, 1);
        rd(2'd3, v); check("R11 addr3 reads zero", v, 0);
        wr(2'd2, 8'h00);
        rd(2'd2, v); check("R11 ctl bit readback clear", v, 0);

        // R6 / R10: live count readback, alternating bytes each clock
        rx_en = 1'b1;
        wr(2'd2, 8'h01);
        for (int j = 0; j < 3; j++) begin
            int n;
            n = (j == 0) ? 5 : (j == 1) ? 13 : 300;
            set_reload(n);
            wait_tick();
            wait_tick();
            for (int k = 1; k < n; k++) begin
                int exp_cnt;
                exp_cnt = n - k;
                @(negedge clk);
                check("R6 no tick mid-count", int'(baud_tick), 0);
                if (k % 2 == 1) begin
                    rd(2'd0, v); check("R10 live high byte", v, (exp_cnt >> 8) & 255);
                end else begin
                    rd(2'd1, v); check("R10 live low byte", v, exp_cnt & 255);
                end
            end
            @(negedge clk);
            check("R6 tick at zero count", int'(baud_tick), 1);
            rd(2'd1, v); check("R6 live low byte zero", v, 0);
        end

        // R8: receiver enabled, bit set: no interrupt
        set_reload(6);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check("R8 irq low with rx enabled", int'(rx_irq), 0);
        end

        // R7: timer mode interrupt follows tick
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check("R7 irq equals tick in timer mode", int'(rx_irq), int'(baud_tick));
        end

        // R9: control bit clear, receiver disabled: no interrupt
        wr(2'd2, 8'h00);
        @(negedge clk);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check("R9 irq low with ctl clear", int'(rx_irq), 0);
        end
        rd(2'd0, v); check("R5 reload view restored high", v, 0);
        rd(2'd1, v); check("R5 reload view restored low", v, 6);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule